// File: doc/BRIEF.md
# Analog-Aware Dual I/O Port Controller

This block controls two 8-bit general-purpose I/O ports of a small 8-bit processor core. Every pin has an output latch bit and a two-bit drive mode. The controller turns these into pad output-enable and output-data signals. It also produces a per-pin digital input enable, which switches off the input buffer of pins that are in use by an analog peripheral. The converter port has all eight pins shared with converter inputs. On the comparator port, pins 4 to 7 are shared with the two comparators and pins 2 and 3 with the DAC.

The analog peripherals stay outside the block. Their enable bits, and the read-modify-write flag from the instruction decoder, arrive as plain inputs. A plain CPU read returns the gated pin levels. A read flagged as read-modify-write returns the latch contents instead, so bit-set, bit-clear, complement and carry-move writes never copy a pin level back into the latch.

Latch and mode writes take effect at the rising clock edge. The read path and the pad controls are combinational from the registered state and the current inputs.

Top module: `aport_ctrl`

## Requirements
- R1: After reset every latch bit is 1. Every converter-port pin and comparator-port pins 2 to 7 are in input-only mode. Comparator-port pins 0 and 1 are in quasi-bidirectional mode.
- R2: A write with wr_en_i=1 takes effect at the next rising clock edge, and the target is chosen by wr_sel_i:
  - 0: converter-port latch, taken from wr_data_i[7:0].
  - 1: comparator-port latch, taken from wr_data_i[7:0].
  - 2: converter-port modes.
  - 3: comparator-port modes.
  - For a mode write, pin n takes its mode from wr_data_i[2n+1:2n], encoded as 00 quasi-bidirectional, 01 push-pull, 10 input-only, 11 open-drain.
- R3: The pad controls follow the pin mode:
  - Push-pull: output enable 1 and output data equal to the latch bit.
  - Open-drain and quasi-bidirectional: output enable equal to the inverted latch bit, with output data 0.
  - Input-only: output enable 0 and output data 0.
- R4: While adc_en_i=1 and dac_sel_i=0, every converter-port pin in input-only mode has its input enable at 0 and reads as 0. Otherwise the converter-port inputs stay enabled.
- R5: While cmp_a_en_i=1 or cmp_b_en_i=1, comparator-port pins 4 to 7 that are in input-only mode have their input enable at 0 and read as 0.
- R6: DAC mode is active while adc_en_i=1 and dac_sel_i=1. In DAC mode, comparator-port pins 2 and 3 behave as input-only whatever their mode bits say, and their digital input is disabled. The stored mode bits are kept and apply again once DAC mode ends.
- R7: A pin in open-drain mode with latch bit 1 does not drive and still reads its pad level while its analog function is active.
- R8: A read with rd_rmw_i=0 returns the pad levels of the port chosen by rd_sel_i (0 converter port, 1 comparator port), ANDed with that port's input enables.
- R9: A read with rd_rmw_i=1 returns the latch of the chosen port, whatever the pad levels and input enables are.
- R10: A pin whose digital input is disabled never has its output enable at 1.
- R11: Disabling a pin's input leaves its latch bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target (latch A, latch B, mode A, mode B) |
| wr_data_i | input | 16 | Write data (latch in [7:0], modes 2 bits per pin) |
| rd_sel_i | input | 1 | Read port: 0 converter port, 1 comparator port |
| rd_rmw_i | input | 1 | Read is read-modify-write |
| rd_data_o | output | 8 | CPU read data |
| adc_en_i | input | 1 | Converter enable |
| dac_sel_i | input | 1 | Converter in DAC mode |
| cmp_a_en_i | input | 1 | Comparator A enable |
| cmp_b_en_i | input | 1 | Comparator B enable |
| pad_a_i | input | 8 | Converter-port pad levels |
| pad_b_i | input | 8 | Comparator-port pad levels |
| pad_a_oe_o | output | 8 | Converter-port output enables |
| pad_a_do_o | output | 8 | Converter-port output data |
| pad_a_ie_o | output | 8 | Converter-port input enables |
| pad_b_oe_o | output | 8 | Comparator-port output enables |
| pad_b_do_o | output | 8 | Comparator-port output data |
| pad_b_ie_o | output | 8 | Comparator-port input enables |

## Verification
Several properties are checked on every cycle:
- A disabled input never comes with an enabled output.
- Output data is never high without an output enable.
- Plain reads never return a 1 for a gated or low pad.
- Both ports keep their inputs enabled while their analog functions are off.
- DAC mode holds pins 2 and 3 undriven and gated.
- A latch write is seen by the following read-modify-write read.

Other behaviours depend on the contents of the mode registers, and only the bench scenarios can show them:
- The drive pattern produced by each mode.
- The reset modes.
- The open-drain escape that keeps a pin readable.
- The return of the stored mode after DAC mode ends.
- The exact cycle at which a write becomes visible.

// File: rtl/aport_pkg.sv
package aport_pkg;
  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_PUSH  = 2'b01,
    PM_INPUT = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_LAT_A  = 2'd0,
    SEL_LAT_B  = 2'd1,
    SEL_MODE_A = 2'd2,
    SEL_MODE_B = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
  import aport_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] ANALOG_MASK = '1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           lat_we_i,
  input  logic           mode_we_i,
  input  logic [W-1:0]   lat_d_i,
  input  logic [2*W-1:0] mode_d_i,
  output logic [W-1:0]   lat_o,
  output logic [2*W-1:0] mode_o
);
  function automatic logic [2*W-1:0] mode_rst_val();
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[2*i +: 2] = ANALOG_MASK[i] ? PM_INPUT : PM_QUASI;
    end
    return r;
  endfunction

  localparam logic [2*W-1:0] MODE_RST = mode_rst_val();

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_o <= '1;
    end else if (lat_we_i) begin
      lat_o <= lat_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
    end else if (mode_we_i) begin
      mode_o <= mode_d_i;
    end
  end
endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl
  import aport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   lat_i,
  input  logic [2*W-1:0] mode_i,
  input  logic [W-1:0]   force_i,  // override to input-only
  input  logic [W-1:0]   gate_i,   // analog function active on pin
  output logic [W-1:0]   oe_o,
  output logic [W-1:0]   do_o,
  output logic [W-1:0]   ie_o
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    pin_mode_e eff;
    logic      oe;

    always_comb begin
      eff = force_i[n] ? PM_INPUT : pin_mode_e'(mode_i[2*n +: 2]);
      unique case (eff)
        PM_PUSH:  oe = 1'b1;
        PM_OPEN,
        PM_QUASI: oe = ~lat_i[n];
        default:  oe = 1'b0;
      endcase
    end

    assign oe_o[n] = oe;
    assign do_o[n] = oe & lat_i[n];
    assign ie_o[n] = ~(gate_i[n] & (eff == PM_INPUT));
  end
endmodule

// File: rtl/port_rd_mux.sv
module port_rd_mux #(
  parameter int unsigned W = 8
) (
  input  logic         sel_i,
  input  logic         rmw_i,
  input  logic [W-1:0] lat_a_i,
  input  logic [W-1:0] lat_b_i,
  input  logic [W-1:0] pad_a_i,
  input  logic [W-1:0] pad_b_i,
  input  logic [W-1:0] ie_a_i,
  input  logic [W-1:0] ie_b_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] pin_a, pin_b;

  assign pin_a = pad_a_i & ie_a_i;
  assign pin_b = pad_b_i & ie_b_i;

  always_comb begin
    if (rmw_i) data_o = sel_i ? lat_b_i : lat_a_i;
    else       data_o = sel_i ? pin_b : pin_a;
  end
endmodule

// File: rtl/aport_ctrl.sv
module aport_ctrl
  import aport_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] A_ANALOG = 8'hFF,
  parameter logic [W-1:0] B_CMP    = 8'hF0,
  parameter logic [W-1:0] B_DAC    = 8'h0C
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [2*W-1:0] wr_data_i,
  input  logic           rd_sel_i,
  input  logic           rd_rmw_i,
  output logic [W-1:0]   rd_data_o,
  input  logic           adc_en_i,
  input  logic           dac_sel_i,
  input  logic           cmp_a_en_i,
  input  logic           cmp_b_en_i,
  input  logic [W-1:0]   pad_a_i,
  input  logic [W-1:0]   pad_b_i,
  output logic [W-1:0]   pad_a_oe_o,
  output logic [W-1:0]   pad_a_do_o,
  output logic [W-1:0]   pad_a_ie_o,
  output logic [W-1:0]   pad_b_oe_o,
  output logic [W-1:0]   pad_b_do_o,
  output logic [W-1:0]   pad_b_ie_o
);
  localparam logic [W-1:0] B_ANALOG = B_CMP | B_DAC;

  logic [W-1:0]   lat_a, lat_b;
  logic [2*W-1:0] mode_a, mode_b;
  logic           dac_on, adc_on, cmp_on;
  logic [W-1:0]   gate_a, gate_b, force_b;

  assign dac_on  = adc_en_i & dac_sel_i;
  assign adc_on  = adc_en_i & ~dac_sel_i;
  assign cmp_on  = cmp_a_en_i | cmp_b_en_i;
  assign gate_a  = {W{adc_on}} & A_ANALOG;
  assign force_b = {W{dac_on}} & B_DAC;
  assign gate_b  = ({W{cmp_on}} & B_CMP) | force_b;

  port_cfg_regs #(.W(W), .ANALOG_MASK(A_ANALOG)) u_regs_a (
    .clk_i, .rst_ni,
    .lat_we_i  (wr_en_i && wr_sel_i == SEL_LAT_A),
    .mode_we_i (wr_en_i && wr_sel_i == SEL_MODE_A),
    .lat_d_i   (wr_data_i[W-1:0]),
    .mode_d_i  (wr_data_i),
    .lat_o     (lat_a),
    .mode_o    (mode_a)
  );

  port_cfg_regs #(.W(W), .ANALOG_MASK(B_ANALOG)) u_regs_b (
    .clk_i, .rst_ni,
    .lat_we_i  (wr_en_i && wr_sel_i == SEL_LAT_B),
    .mode_we_i (wr_en_i && wr_sel_i == SEL_MODE_B),
    .lat_d_i   (wr_data_i[W-1:0]),
    .mode_d_i  (wr_data_i),
    .lat_o     (lat_b),
    .mode_o    (mode_b)
  );

  pad_ctrl #(.W(W)) u_pad_a (
    .lat_i (lat_a), .mode_i (mode_a), .force_i ('0), .gate_i (gate_a),
    .oe_o (pad_a_oe_o), .do_o (pad_a_do_o), .ie_o (pad_a_ie_o)
  );

  pad_ctrl #(.W(W)) u_pad_b (
    .lat_i (lat_b), .mode_i (mode_b), .force_i (force_b), .gate_i (gate_b),
    .oe_o (pad_b_oe_o), .do_o (pad_b_do_o), .ie_o (pad_b_ie_o)
  );

  port_rd_mux #(.W(W)) u_rd (
    .sel_i (rd_sel_i), .rmw_i (rd_rmw_i),
    .lat_a_i (lat_a), .lat_b_i (lat_b),
    .pad_a_i, .pad_b_i,
    .ie_a_i (pad_a_ie_o), .ie_b_i (pad_b_ie_o),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/aport_ctrl_chk.sv
module aport_ctrl_chk #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] B_DAC = 8'h0C
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [1:0]     wr_sel_i,
  input logic [2*W-1:0] wr_data_i,
  input logic           rd_sel_i,
  input logic           rd_rmw_i,
  input logic [W-1:0]   rd_data_o,
  input logic           adc_en_i,
  input logic           dac_sel_i,
  input logic           cmp_a_en_i,
  input logic           cmp_b_en_i,
  input logic [W-1:0]   pad_a_i,
  input logic [W-1:0]   pad_a_oe_o,
  input logic [W-1:0]   pad_a_do_o,
  input logic [W-1:0]   pad_a_ie_o,
  input logic [W-1:0]   pad_b_oe_o,
  input logic [W-1:0]   pad_b_do_o,
  input logic [W-1:0]   pad_b_ie_o
);
  AST_GATED_A_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_a_oe_o & ~pad_a_ie_o) == '0); // R10
  AST_GATED_B_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_b_oe_o & ~pad_b_ie_o) == '0); // R10
  AST_DATA_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_a_do_o & ~pad_a_oe_o) | (pad_b_do_o & ~pad_b_oe_o)) == '0); // R3
  AST_ADC_OFF_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adc_en_i && !dac_sel_i) |-> pad_a_ie_o == '1); // R4
  AST_CMP_OFF_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmp_a_en_i || cmp_b_en_i || (adc_en_i && dac_sel_i)) |-> pad_b_ie_o == '1); // R5
  AST_DAC_PINS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_en_i && dac_sel_i) |-> ((pad_b_oe_o | pad_b_ie_o) & B_DAC) == '0); // R6
  AST_PLAIN_READ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_rmw_i && !rd_sel_i) |-> (rd_data_o & ~(pad_a_i & pad_a_ie_o)) == '0); // R8
  AST_RMW_SEES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && wr_sel_i == 2'd0) && rd_rmw_i && !rd_sel_i)
    |-> rd_data_o == $past(wr_data_i[W-1:0])); // R9
endmodule

bind aport_ctrl aport_ctrl_chk #(.W(W), .B_DAC(B_DAC)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .rd_sel_i, .rd_rmw_i,
  .rd_data_o, .adc_en_i, .dac_sel_i, .cmp_a_en_i, .cmp_b_en_i, .pad_a_i,
  .pad_a_oe_o, .pad_a_do_o, .pad_a_ie_o, .pad_b_oe_o, .pad_b_do_o, .pad_b_ie_o
);

// File: tb/test_aport_ctrl.sv
module test_aport_ctrl;
  logic        clk_i = 0, rst_ni = 0;
  logic        wr_en_i = 0;
  logic [1:0]  wr_sel_i = 0;
  logic [15:0] wr_data_i = 0;
  logic        rd_sel_i = 0, rd_rmw_i = 0;
  logic [7:0]  rd_data_o;
  logic        adc_en_i = 0, dac_sel_i = 0, cmp_a_en_i = 0, cmp_b_en_i = 0;
  logic [7:0]  pad_a_i = 8'hFF, pad_b_i = 8'hFF;
  logic [7:0]  pad_a_oe_o, pad_a_do_o, pad_a_ie_o, pad_b_oe_o, pad_b_do_o, pad_b_ie_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  aport_ctrl i_aport_ctrl (.*);

  typedef struct packed {
    logic [15:0] mode;
    logic [7:0]  lat;
    logic        adc;
    logic        dac;
    logic [7:0]  pad;
    logic [7:0]  oe;
    logic [7:0]  dout;
    logic [7:0]  rd;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h5555, 8'hA5, 1'b0, 1'b0, 8'h3C, 8'hFF, 8'hA5, 8'h3C},
    '{16'hFFFF, 8'h0F, 1'b0, 1'b0, 8'hF0, 8'hF0, 8'h00, 8'hF0},
    '{16'h0000, 8'h33, 1'b1, 1'b0, 8'hFF, 8'hCC, 8'h00, 8'hFF},
    '{16'hAAAA, 8'hFF, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00},
    '{16'hAAAA, 8'hFF, 1'b1, 1'b1, 8'h5A, 8'h00, 8'h00, 8'h5A},
    '{16'hAAAA, 8'hFF, 1'b0, 1'b0, 8'h96, 8'h00, 8'h00, 8'h96},
    '{16'hFFAA, 8'hF0, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00, 8'hF0},
    '{16'h5500, 8'h5A, 1'b1, 1'b0, 8'h0F, 8'hF5, 8'h50, 8'h0F}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(input logic sel, input logic rmw);
    rd_sel_i = sel; rd_rmw_i = rmw;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 oe A", pad_a_oe_o, 8'h00);
    chk("R1 oe B", pad_b_oe_o, 8'h00);
    rd(0, 1); chk("R1 latch A", rd_data_o, 8'hFF);
    rd(1, 1); chk("R1 latch B", rd_data_o, 8'hFF);
    rd(0, 0); chk("R1 plain A no gate", rd_data_o, 8'hFF);
    adc_en_i = 1; rd(0, 0);
    chk("R1 R4 A input-only after reset", rd_data_o, 8'h00);
    adc_en_i = 0;
    cmp_a_en_i = 1; rd(1, 0);
    chk("R1 R5 B pins 4-7 input-only", rd_data_o, 8'h0F);
    cmp_a_en_i = 0;
    wr(2'd1, 16'h0000);
    chk("R1 B pins 0-1 quasi", pad_b_oe_o, 8'h03);

    // R3 R4 R7 R8 table
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, VECS[i].mode);
      wr(2'd0, {8'h00, VECS[i].lat});
      adc_en_i = VECS[i].adc; dac_sel_i = VECS[i].dac; pad_a_i = VECS[i].pad;
      rd(0, 0);
      chk($sformatf("R3 oe vec%0d", i), pad_a_oe_o, VECS[i].oe);
      chk($sformatf("R3 do vec%0d", i), pad_a_do_o, VECS[i].dout);
      chk($sformatf("R4 R7 R8 read vec%0d", i), rd_data_o, VECS[i].rd);
    end
    adc_en_i = 0; dac_sel_i = 0;

    // R2 write timing
    wr(2'd0, 16'h0011);
    rd(0, 1);
    @(negedge clk_i);
    wr_en_i = 1; wr_sel_i = 2'd0; wr_data_i = 16'h003C;
    @(posedge clk_i); #1;
    chk("R2 latch after edge", rd_data_o, 8'h3C);
    @(negedge clk_i); wr_en_i = 0;
    wr(2'd0, 16'h00C3);
    chk("R2 latch update", rd_data_o, 8'hC3);

    // R5 comparator B alone
    wr(2'd3, 16'hAAAA);
    pad_b_i = 8'hFF; cmp_b_en_i = 1; rd(1, 0);
    chk("R5 cmp B gating", rd_data_o, 8'h0F);
    cmp_b_en_i = 0; rd(1, 0);
    chk("R5 cmp off", rd_data_o, 8'hFF);

    // R6 DAC override
    wr(2'd3, 16'h5555);
    wr(2'd1, 16'h00FF);
    adc_en_i = 1; dac_sel_i = 1; rd(1, 0);
    chk("R6 DAC oe", pad_b_oe_o, 8'hF3);
    chk("R6 DAC do", pad_b_do_o, 8'hF3);
    chk("R6 DAC read", rd_data_o, 8'hF3);
    adc_en_i = 0; dac_sel_i = 0; #1;
    chk("R6 mode restored", pad_b_oe_o, 8'hFF);

    // R7 open-drain escape on comparator port
    wr(2'd3, 16'hAFAA);
    cmp_a_en_i = 1; pad_b_i = 8'hFF; rd(1, 0);
    chk("R7 open-drain readable", rd_data_o, 8'h3F);
    chk("R10 open-drain undriven", pad_b_oe_o, 8'h00);

    // R9 R11 rmw returns latch
    wr(2'd3, 16'hAAAA);
    wr(2'd1, 16'h00A5);
    pad_b_i = 8'h00; rd(1, 1);
    chk("R9 R11 rmw latch", rd_data_o, 8'hA5);
    rd(1, 0);
    chk("R8 plain pins", rd_data_o, 8'h00);
    cmp_a_en_i = 0; pad_b_i = 8'hFF; rd(1, 1);
    chk("R11 latch kept", rd_data_o, 8'hA5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule